// File: doc/BRIEF.md
# Complement-folding reduced-bit multiplier

This block multiplies two unsigned 4-bit operands and returns the 8-bit product. It never instantiates anything wider than a 2x2-bit multiplier. Each operand first loses its trailing zero bits, which leaves two odd values. Four reduction stages then shrink those odd values. Two of the stages fold an operand pair onto its complement from a power of two (16, then 8). The other two split off the top power of two from the larger operand (8, then 4). After the reductions, a 2x2 multiply or a pass-through for a unit operand gives a partial product. The stages that fired are then undone in reverse order, and a final left shift puts back the stripped zeros.

The block runs as a small sequencer. The caller presents both operands with a one-cycle `start` while the block is idle. `busy` stays high while the stages run. `done` pulses for one cycle when `product` and `path_flags` are valid, and both hold their values until the next result. `path_flags` reports which of the four reduction stages fired.

Top module: `rbm_mul`

## Requirements
- R1: While reset is held, and right after it is released, `busy` and `done` are low and `product` and `path_flags` are zero.
- R2: For every pair of 4-bit operands, `product` equals their exact unsigned product in the cycle `done` is high.
- R3: When both operands are nonzero, `done` goes high on the 10th rising edge after the edge that accepts `start` and stays high for exactly one cycle. `busy` is high in between and is low whenever `done` is high.
- R4: When either operand is zero, `done` goes high on the first edge after the accepting edge, with `product` = 0 and `path_flags` = 0.
- R5: A `start` seen while `busy` is high has no effect: the running result is unchanged, no extra `done` follows, and `product` and `path_flags` hold between results.
- R6: Both operands are shifted right to odd values before any stage runs. `path_flags` therefore depends only on the odd parts, and the product is shifted left by the sum of the two trailing-zero counts.
- R7: `path_flags[0]` is set when both odd parts exceed 8. Each is then replaced by 16 minus itself.
- R8: `path_flags[1]` is set when, after stage 0, one operand exceeds 8 and the other exceeds 2. The larger operand then loses 8.
- R9: `path_flags[2]` is set when, after stage 1, both operands exceed 4. Each is then replaced by 8 minus itself.
- R10: `path_flags[3]` is set when, after stage 2, one operand exceeds 4 and the other exceeds 2. The larger operand then loses 4.
- R11: If either remaining operand equals 1, the partial product is the other operand. Otherwise both remaining operands are at most 3 and the 2x2 core forms the partial product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a multiply when sampled high while idle |
| op_a | input | 4 | First unsigned operand |
| op_b | input | 4 | Second unsigned operand |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| product | output | 8 | Unsigned product, held until the next result |
| path_flags | output | 4 | Bit k set when reduction stage k fired (0: fold at 16, 1: split at 8, 2: fold at 8, 3: split at 4) |

## Verification
The full set of 256 operand pairs is run, and each result is compared with the plain product and with path flags computed by an independent model. This covers every combination of folding and splitting. Hand-picked pairs such as 15x15, 9x3, 7x7 and 13x11 each drive one particular stage, so a wrong threshold or a wrong base shows up in a specific flag bit and not only as a bad product. Operands with trailing zeros (12x10, 8x8) are compared with their odd counterparts, which separates stripping and restore-shift faults from faults in the reduction stages. Zero and unit operands check the bypass paths, and a start pulse sent mid-run checks that a busy block ignores new requests.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int OP_W   = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int NSTAGE = 4;
  localparam int IDX_W  = $clog2(NSTAGE);
  localparam int TZ_W   = $clog2(OP_W);
  localparam int SH_W   = TZ_W + 1;
  localparam int CORE_W = 2;

  typedef logic [OP_W-1:0]   opnd_t;
  typedef logic [PROD_W-1:0] prod_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RED0, ST_RED1, ST_RED2, ST_RED3, ST_CORE,
    ST_REB3, ST_REB2, ST_REB1, ST_REB0, ST_FIN
  } phase_t;

  // index of the lowest set bit (0 for a zero input)
  function automatic logic [TZ_W-1:0] trail_zeros(opnd_t v);
    logic [TZ_W-1:0] n;
    n = '0;
    for (int i = OP_W - 1; i >= 0; i--)
      if (v[i]) n = TZ_W'(i);
    return n;
  endfunction

  // even stages fold onto a complement, odd stages split off a power of two
  function automatic bit stage_folds(int unsigned k);
    return (k % 2) == 0;
  endfunction

  function automatic int unsigned stage_base(int unsigned k);
    if (stage_folds(k)) return 1 << (OP_W - k / 2);
    return 1 << (OP_W - 1 - k / 2);
  endfunction

  // undo a fold: high part = base - (ca + cb) + carry of low part
  function automatic prod_t fold_rebuild(opnd_t ca, opnd_t cb, prod_t p, int unsigned lg);
    prod_t base, upper, lower;
    base  = prod_t'(1) << lg;
    upper = base - prod_t'(ca) - prod_t'(cb) + (p >> lg);
    lower = p & (base - prod_t'(1));
    return (upper << lg) | lower;
  endfunction

  // undo a split: add kept operand times the base
  function automatic prod_t split_rebuild(opnd_t keep, prod_t p, int unsigned lg);
    return (prod_t'(keep) << lg) + p;
  endfunction
endpackage

// File: rtl/rbm_core.sv
module rbm_core
  import rbm_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  output prod_t p
);
  localparam opnd_t ONE = opnd_t'(1);

  logic [2*CORE_W-1:0] small_prod;

  assign small_prod = {{CORE_W{1'b0}}, a[CORE_W-1:0]} * {{CORE_W{1'b0}}, b[CORE_W-1:0]};

  always_comb begin
    if (a == ONE)      p = prod_t'(b);
    else if (b == ONE) p = prod_t'(a);
    else               p = prod_t'(small_prod);
  end
endmodule

// File: rtl/rbm_strip.sv
module rbm_strip
  import rbm_pkg::*;
(
  input  opnd_t           a,
  input  opnd_t           b,
  output opnd_t           sa,
  output opnd_t           sb,
  output logic [SH_W-1:0] shamt,
  output logic            any_zero
);
  logic [TZ_W-1:0] za, zb;

  assign za       = trail_zeros(a);
  assign zb       = trail_zeros(b);
  assign sa       = a >> za;
  assign sb       = b >> zb;
  assign shamt    = SH_W'(za) + SH_W'(zb);
  assign any_zero = (a == '0) || (b == '0);
endmodule

// File: rtl/rbm_reduce.sv
module rbm_reduce
  import rbm_pkg::*;
#(
  parameter int unsigned STAGE = 0
) (
  input  opnd_t a,
  input  opnd_t b,
  output opnd_t nx_a,
  output opnd_t nx_b,
  output logic  take
);
  localparam int unsigned    BASE   = stage_base(STAGE);
  localparam logic [OP_W:0]  BASE_W = (OP_W + 1)'(BASE);

  logic [OP_W:0] wa, wb;
  assign wa = {1'b0, a};
  assign wb = {1'b0, b};

  generate
    if (stage_folds(STAGE)) begin : g_fold
      localparam logic [OP_W:0] HALF_W = BASE_W >> 1;
      opnd_t ca, cb;
      assign take = (wa > HALF_W) && (wb > HALF_W);
      assign ca   = OP_W'(BASE_W - wa);
      assign cb   = OP_W'(BASE_W - wb);
      assign nx_a = take ? ca : a;
      assign nx_b = take ? cb : b;
    end else begin : g_split
      localparam logic [OP_W:0] KEEP_MIN = (OP_W + 1)'(2);
      logic          b_big;
      logic [OP_W:0] mx, mn;
      opnd_t         dif;
      assign b_big = wb > wa;
      assign mx    = b_big ? wb : wa;
      assign mn    = b_big ? wa : wb;
      assign take  = (mx > BASE_W) && (mn > KEEP_MIN);
      assign dif   = OP_W'(mx - BASE_W);
      assign nx_a  = (take && !b_big) ? dif : a;
      assign nx_b  = (take &&  b_big) ? dif : b;
    end
  endgenerate
endmodule

// File: rtl/rbm_mul.sv
module rbm_mul
  import rbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              busy,
  output logic              done,
  output logic [PROD_W-1:0] product,
  output logic [NSTAGE-1:0] path_flags
);
  phase_t st, nxt;
  opnd_t  cur_a, cur_b;
  prod_t  acc;
  logic [NSTAGE-1:0] flg;
  opnd_t  pre_a [NSTAGE];
  opnd_t  pre_b [NSTAGE];
  logic [SH_W-1:0] shamt_q;
  logic   zero_q;
  prod_t  product_q;
  logic [NSTAGE-1:0] flags_q;
  logic   done_q;

  // strip stage
  opnd_t s_a, s_b;
  logic [SH_W-1:0] s_sh;
  logic s_zero;

  rbm_strip u_strip (
    .a(op_a), .b(op_b), .sa(s_a), .sb(s_b), .shamt(s_sh), .any_zero(s_zero)
  );

  // core multiply
  prod_t core_p;
  rbm_core u_core (.a(cur_a), .b(cur_b), .p(core_p));

  // per-stage reduce and rebuild
  opnd_t red_a [NSTAGE];
  opnd_t red_b [NSTAGE];
  logic [NSTAGE-1:0] take_v;
  prod_t reb_p [NSTAGE];

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int unsigned LG = $clog2(stage_base(k));
    rbm_reduce #(.STAGE(k)) u_red (
      .a(cur_a), .b(cur_b), .nx_a(red_a[k]), .nx_b(red_b[k]), .take(take_v[k])
    );
    if (stage_folds(k)) begin : g_f
      assign reb_p[k] = fold_rebuild(cur_a, cur_b, acc, LG);
    end else begin : g_s
      // the kept operand is the one the split left untouched
      assign reb_p[k] = split_rebuild((pre_a[k] == cur_a) ? cur_a : cur_b, acc, LG);
    end
  end

  logic [IDX_W-1:0] red_k, reb_k;

  always_comb begin
    nxt   = st;
    red_k = '0;
    reb_k = '0;
    case (st)
      ST_IDLE: if (start) nxt = s_zero ? ST_FIN : ST_RED0;
      ST_RED0: begin red_k = IDX_W'(0); nxt = ST_RED1; end
      ST_RED1: begin red_k = IDX_W'(1); nxt = ST_RED2; end
      ST_RED2: begin red_k = IDX_W'(2); nxt = ST_RED3; end
      ST_RED3: begin red_k = IDX_W'(3); nxt = ST_CORE; end
      ST_CORE: nxt = ST_REB3;
      ST_REB3: begin reb_k = IDX_W'(3); nxt = ST_REB2; end
      ST_REB2: begin reb_k = IDX_W'(2); nxt = ST_REB1; end
      ST_REB1: begin reb_k = IDX_W'(1); nxt = ST_REB0; end
      ST_REB0: begin reb_k = IDX_W'(0); nxt = ST_FIN;  end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_a     <= '0;
      cur_b     <= '0;
      acc       <= '0;
      flg       <= '0;
      shamt_q   <= '0;
      zero_q    <= 1'b0;
      product_q <= '0;
      flags_q   <= '0;
      done_q    <= 1'b0;
      for (int k = 0; k < NSTAGE; k++) begin
        pre_a[k] <= '0;
        pre_b[k] <= '0;
      end
    end else begin
      st     <= nxt;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          flg     <= '0;
          acc     <= '0;
          zero_q  <= s_zero;
          shamt_q <= s_sh;
          cur_a   <= s_a;
          cur_b   <= s_b;
          for (int k = 0; k < NSTAGE; k++) begin
            pre_a[k] <= '0;
            pre_b[k] <= '0;
          end
        end
        ST_RED0, ST_RED1, ST_RED2, ST_RED3: begin
          pre_a[red_k] <= cur_a;
          pre_b[red_k] <= cur_b;
          if (take_v[red_k]) begin
            cur_a      <= red_a[red_k];
            cur_b      <= red_b[red_k];
            flg[red_k] <= 1'b1;
          end
        end
        ST_CORE: acc <= core_p;
        ST_REB3, ST_REB2, ST_REB1, ST_REB0: begin
          if (flg[reb_k]) begin
            acc   <= reb_p[reb_k];
            cur_a <= pre_a[reb_k];
            cur_b <= pre_b[reb_k];
          end
        end
        ST_FIN: begin
          product_q <= zero_q ? '0 : (acc << shamt_q);
          flags_q   <= flg;
          done_q    <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign product    = product_q;
  assign path_flags = flags_q;
endmodule

// File: rtl/rbm_mul_chk.sv
module rbm_mul_chk
  import rbm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              busy,
  input logic              done,
  input logic [PROD_W-1:0] product,
  input logic [NSTAGE-1:0] path_flags,
  input phase_t            st,
  input opnd_t             cur_a,
  input opnd_t             cur_b
);
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_a != '0 && op_b != '0) |-> ##11 done);

  a_r4_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op_a == '0 || op_b == '0)) |-> ##2 (done && product == '0 && path_flags == '0));

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(product) && $stable(path_flags)));

  a_r6_odd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RED0) |-> (cur_a[0] && cur_b[0]));

  a_r11_core_small: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CORE && cur_a != opnd_t'(1) && cur_b != opnd_t'(1)) |-> (cur_a <= opnd_t'(3) && cur_b <= opnd_t'(3)));
endmodule

bind rbm_mul rbm_mul_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
  .busy(busy), .done(done), .product(product), .path_flags(path_flags),
  .st(st), .cur_a(cur_a), .cur_b(cur_b)
);

// File: tb/rbm_mul_tb.sv
module rbm_mul_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic       busy, done;
  logic [7:0] product;
  logic [3:0] path_flags;

  int n_chk = 0;
  int n_bad = 0;
  int hits [4] = '{0, 0, 0, 0};
  bit over = 1'b0;

  always #5ns clk = ~clk;

  rbm_mul u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product), .path_flags(path_flags)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent model of the stage decisions
  function automatic logic [3:0] model_flags(int x, int y);
    logic [3:0] f = '0;
    int hi, lo;
    if (x == 0 || y == 0) return '0;
    while (x % 2 == 0) x = x / 2;
    while (y % 2 == 0) y = y / 2;
    if (x > 8 && y > 8) begin x = 16 - x; y = 16 - y; f[0] = 1'b1; end
    hi = (x > y) ? x : y; lo = (x > y) ? y : x;
    if (hi > 8 && lo > 2) begin f[1] = 1'b1; if (x > y) x = x - 8; else y = y - 8; end
    if (x > 4 && y > 4) begin x = 8 - x; y = 8 - y; f[2] = 1'b1; end
    hi = (x > y) ? x : y; lo = (x > y) ? y : x;
    if (hi > 4 && lo > 2) f[3] = 1'b1;
    return f;
  endfunction

  task automatic run_op(input logic [3:0] a, input logic [3:0] b,
                        output logic [7:0] p, output logic [3:0] f, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    p = product;
    f = path_flags;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(product == 0 && path_flags == 0, "R1", "outputs in reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && product == 0 && path_flags == 0, "R1", "after release", product, 0);
  endtask

  task automatic t_all_pairs;
    logic [7:0] p;
    logic [3:0] f;
    int lat;
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        run_op(4'(ia), 4'(ib), p, f, lat);
        chk(p == 8'(ia * ib), "R2", $sformatf("product %0dx%0d", ia, ib), p, ia * ib);
        chk(f == model_flags(ia, ib), "R7 R8 R9 R10", $sformatf("flags %0dx%0d", ia, ib), f, model_flags(ia, ib));
        if (ia == 0 || ib == 0)
          chk(lat == 1, "R4", $sformatf("zero latency %0dx%0d", ia, ib), lat, 1);
        else
          chk(lat == 10, "R3", $sformatf("latency %0dx%0d", ia, ib), lat, 10);
        for (int k = 0; k < 4; k++) if (f[k]) hits[k]++;
      end
    end
    $display("stage hits: fold16=%0d split8=%0d fold8=%0d split4=%0d", hits[0], hits[1], hits[2], hits[3]);
    chk(hits[0] > 0, "R7", "fold-16 path used", hits[0], 1);
    chk(hits[1] > 0, "R8", "split-8 path used", hits[1], 1);
    chk(hits[2] > 0, "R9", "fold-8 path used", hits[2], 1);
    chk(hits[3] > 0, "R10", "split-4 path used", hits[3], 1);
  endtask

  task automatic t_paths;
    logic [7:0] p;
    logic [3:0] f;
    int lat;
    run_op(4'd15, 4'd15, p, f, lat);
    chk(f == 4'b0001 && p == 225, "R7", "15x15 flags", f, 1);
    run_op(4'd9, 4'd3, p, f, lat);
    chk(f == 4'b0010 && p == 27, "R8", "9x3 flags", f, 2);
    run_op(4'd7, 4'd7, p, f, lat);
    chk(f == 4'b0100 && p == 49, "R9", "7x7 flags", f, 4);
    run_op(4'd13, 4'd11, p, f, lat);
    chk(f == 4'b1001 && p == 143, "R10", "13x11 flags", f, 9);
  endtask

  task automatic t_strip;
    logic [7:0] p, p_odd;
    logic [3:0] f, f_odd;
    int lat;
    run_op(4'd3, 4'd5, p_odd, f_odd, lat);
    run_op(4'd12, 4'd10, p, f, lat);
    chk(f == f_odd && f == 4'b1000, "R6", "12x10 flags match 3x5", f, f_odd);
    chk(p == 120 && p_odd == 15, "R6", "12x10 restore shift", p, 120);
    run_op(4'd8, 4'd8, p, f, lat);
    chk(p == 64 && f == 0, "R6", "8x8 all stripped", p, 64);
  endtask

  task automatic t_unit;
    logic [7:0] p;
    logic [3:0] f;
    int lat;
    run_op(4'd15, 4'd1, p, f, lat);
    chk(p == 15 && f == 0, "R11", "15x1 pass-through", p, 15);
    run_op(4'd1, 4'd13, p, f, lat);
    chk(p == 13 && f == 0, "R11", "1x13 pass-through", p, 13);
    run_op(4'd3, 4'd3, p, f, lat);
    chk(p == 9 && f == 0, "R11", "3x3 core multiply", p, 9);
  endtask

  task automatic t_busy_start;
    int lat, extra;
    logic [7:0] held;
    @(negedge clk);
    op_a = 4'd13; op_b = 4'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op_a = 4'd2; op_b = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 10, "R5", "latency with stray start", lat, 10);
    chk(product == 143, "R5", "result with stray start", product, 143);
    held = product;
    extra = 0;
    repeat (14) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R5", "no second done", extra, 0);
    chk(product == held && path_flags == 4'b1001, "R5", "result held", product, held);
  endtask

  initial begin
    t_reset();
    t_all_pairs();
    t_paths();
    t_strip();
    t_unit();
    t_busy_start();
    if (!over) begin
      over = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!over) begin
      over = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule